// File: doc/BRIEF.md
# GPIO Expander Register Core

This block holds the registers of an eight-pin port expander that sits behind a serial-bus slave. A byte-level front end, which has already matched the device address and framed the transfer, presents each received byte on `wr_data` together with a strobe. `cmd_valid` marks the byte that selects a register. `wr_valid` marks a data byte bound for the selected register. `rd_req` asks for one byte from the selected register. The block keeps a selection pointer, an output-value register, a read-inversion register and a direction register. It drives the pin values and the pin output enables, and it returns read data one cycle after each request.

The pin levels enter through a two-flop synchroniser, and the synchronised value serves as the input register. A read of the input register returns these levels, with each bit flipped where the inversion register holds a 1. The selection pointer never advances on its own, so a run of reads keeps returning the same register until a new command byte arrives. The reset is synchronous and active high.

Top module: `gpio_xpdr_core`

## Requirements
- R1: After reset the output register is 0xFF, the inversion register is 0x00, the direction register is 0xFF and the pointer selects the input register. As a result `pin_oe` is 0x00, `pin_out` is 0xFF and `rd_valid` is 0.
- R2: A byte with `cmd_valid` high and a value of 0, 1, 2 or 3 selects the input, output, inversion or direction register respectively, from the next cycle onward.
- R3: A command byte with a value from 4 to 255 leaves the pointer unchanged and writes no register.
- R4: The pointer does not advance: consecutive reads with no command byte between them return the same register.
- R5: A byte with `wr_valid` high, and `cmd_valid` low, is written into the selected register of the output, inversion and direction registers. When several such bytes arrive, the last one is the value kept.
- R6: Writes while the input register is selected change no register.
- R7: A read of the input register returns the synchronised level of every pin, whatever its direction, XOR the inversion register. A pin level reaches the read path after two clock edges.
- R8: A read of the output register returns the stored register value, not the pin levels.
- R9: `pin_out` equals the output register and `pin_oe[n]` equals the inverse of direction bit n. Both follow a write from the cycle after it.
- R10: `rd_valid` and `rd_data` appear one cycle after `rd_req`. A read in the same cycle as a write returns the value held before the write. A read in the same cycle as a command byte uses the previous pointer.
- R11: If `cmd_valid` and `wr_valid` are high together, the byte is taken only as a command and no register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | `wr_data` is a command byte |
| wr_valid | input | 1 | `wr_data` is a data byte for the selected register |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request one byte from the selected register |
| pin_in | input | 8 | Pin levels (asynchronous) |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous request |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output enable per pin, 1 = driving |

## Verification
Three pairs of functions can fall in the same cycle. A read can coincide with a write to the same register, a read can coincide with a command byte, and a command byte can coincide with a data byte. The stimulus raises these pairs together, both in directed steps and through random strobe combinations. A bench model then judges the result: it takes the read value from the state before the edge and applies the command before any write. The pins also change randomly while reads of the input register are in flight, so the two-edge synchroniser delay is checked too.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } sel_e;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output sel_e          ptr_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] pol_q,
  output logic [DW-1:0] dir_q
);
  localparam int NSEL = 1 << SEL_W;

  logic cmd_ok;
  assign cmd_ok = (wr_data >> SEL_W) == '0 && int'(wr_data) < NSEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= SEL_IN;
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else if (cmd_valid) begin
      if (cmd_ok) ptr_q <= sel_e'(wr_data[SEL_W-1:0]);
    end else if (wr_valid) begin
      case (ptr_q)
        SEL_OUT: out_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (out_q == '1 && pol_q == '0 && dir_q == '1 && ptr_q == SEL_IN)); // R1
  AST_BAD_CMD_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && wr_data > DW'(3)) |=> $stable(ptr_q)); // R3
  AST_PTR_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(ptr_q)); // R4
  AST_INPUT_SEL_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && ptr_q == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q))); // R6
  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q))); // R11
endmodule

// File: rtl/gx_rdmux.sv
module gx_rdmux
  import gx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  sel_e          ptr_q,
  input  logic [DW-1:0] in_q,
  input  logic [DW-1:0] out_q,
  input  logic [DW-1:0] pol_q,
  input  logic [DW-1:0] dir_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] sel_val;

  always_comb begin
    case (ptr_q)
      SEL_IN:  sel_val = in_q ^ pol_q;
      SEL_OUT: sel_val = out_q;
      SEL_POL: sel_val = pol_q;
      default: sel_val = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel_val;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R10
  AST_OUT_READ_IS_FLOP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ptr_q == SEL_OUT) |=> rd_data == $past(out_q)); // R8
endmodule

// File: rtl/gpio_xpdr_core.sv
module gpio_xpdr_core
  import gx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] pin_oe
);
  sel_e          ptr_q;
  logic [DW-1:0] in_q, out_q, pol_q, dir_q;

  gx_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(in_q)
  );

  gx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
    .wr_data(wr_data), .ptr_q(ptr_q), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q)
  );

  gx_rdmux #(.DW(DW)) u_rdmux (
    .clk(clk), .rst(rst), .rd_req(rd_req), .ptr_q(ptr_q), .in_q(in_q),
    .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  AST_OE_FOLLOWS_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_valid && ptr_q == SEL_DIR) |=> pin_oe == ~$past(wr_data)); // R9
  AST_PIN_FOLLOWS_OUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_valid && ptr_q == SEL_OUT) |=> pin_out == $past(wr_data)); // R5
endmodule

// File: tb/sim_gpio_xpdr_core.sv
module sim_gpio_xpdr_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0, pin_in = '0;
  logic [7:0] rd_data, pin_out, pin_oe;
  logic       rd_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m_out, m_pol, m_dir, m_s1, m_s2;
  int         m_ptr;

  always #2 clk = ~clk;

  gpio_xpdr_core u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .pin_in(pin_in), .rd_data(rd_data),
    .rd_valid(rd_valid), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [7:0] model_sel(int p);
    case (p)
      0: return m_s2 ^ m_pol;
      1: return m_out;
      2: return m_pol;
      default: return m_dir;
    endcase
  endfunction

  function automatic string tag_for(int p);
    case (p)
      0: return "R7";
      1: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_out = 8'hFF; m_pol = 8'h00; m_dir = 8'hFF; m_s1 = '0; m_s2 = '0; m_ptr = 0;
  endtask

  task automatic cyc(bit c, bit w, bit r, logic [7:0] d, logic [7:0] p, string tag);
    logic [7:0] exp;
    string t;
    @(negedge clk);
    cmd_valid = c; wr_valid = w; rd_req = r; wr_data = d; pin_in = p;
    @(posedge clk);
    exp = model_sel(m_ptr);
    t = (tag == "") ? tag_for(m_ptr) : tag;
    if (c) begin
      if (d < 8'd4) m_ptr = int'(d);
    end else if (w) begin
      case (m_ptr)
        1: m_out = d;
        2: m_pol = d;
        3: m_dir = d;
        default: ;
      endcase
    end
    m_s2 = m_s1; m_s1 = p;
    #1;
    check8("R10", "rd_valid", {7'd0, rd_valid}, {7'd0, r});
    if (r) check8(t, "rd_data", rd_data, exp);
    check8("R9", "pin_out", pin_out, m_out);
    check8("R9", "pin_oe", pin_oe, ~m_dir);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pins;
    void'($urandom(32'h5EED_0A5B));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    check8("R1", "pin_out", pin_out, 8'hFF);
    check8("R1", "pin_oe", pin_oe, 8'h00);
    check8("R1", "rd_valid", {7'd0, rd_valid}, 8'h00);
    pins = 8'hA5;
    cyc(0, 0, 1, 8'h00, pins, "R1");       // pointer on input, sync still cleared
    cyc(1, 0, 0, 8'h01, pins, "R2");
    cyc(0, 0, 1, 8'h00, pins, "R1");       // output reg reads 0xFF
    cyc(1, 0, 0, 8'h02, pins, "R2");
    cyc(0, 0, 1, 8'h00, pins, "R1");       // polarity reads 0x00
    // R5 last write wins, R4 repeated reads
    cyc(1, 0, 0, 8'h03, pins, "R2");
    cyc(0, 1, 0, 8'h0F, pins, "R5");
    cyc(0, 1, 0, 8'h5A, pins, "R5");
    cyc(0, 0, 1, 8'h00, pins, "R4");
    cyc(0, 0, 1, 8'h00, pins, "R4");
    cyc(0, 0, 1, 8'h00, pins, "R4");
    // R3 invalid commands
    cyc(1, 0, 0, 8'h09, pins, "R3");
    cyc(0, 0, 1, 8'h00, pins, "R3");
    cyc(1, 0, 0, 8'hFF, pins, "R3");
    cyc(0, 0, 1, 8'h00, pins, "R3");
    cyc(1, 0, 0, 8'h04, pins, "R3");
    cyc(0, 0, 1, 8'h00, pins, "R3");
    // R6 writes to input register ignored
    cyc(1, 0, 0, 8'h00, pins, "R2");
    cyc(0, 1, 0, 8'h00, pins, "R6");
    cyc(1, 0, 0, 8'h01, pins, "R6");
    cyc(0, 0, 1, 8'h00, pins, "R6");
    cyc(1, 0, 0, 8'h03, pins, "R6");
    cyc(0, 0, 1, 8'h00, pins, "R6");
    // R7 inversion on input read, pins settle through the synchroniser
    cyc(1, 0, 0, 8'h02, pins, "R2");
    cyc(0, 1, 0, 8'hF0, pins, "R7");
    cyc(1, 0, 0, 8'h00, 8'h3C, "R7");
    cyc(0, 0, 0, 8'h00, 8'h3C, "R7");
    cyc(0, 0, 0, 8'h00, 8'h3C, "R7");
    cyc(0, 0, 1, 8'h00, 8'h3C, "R7");      // 0x3C ^ 0xF0 = 0xCC
    cyc(0, 0, 1, 8'h00, 8'hC3, "R7");      // new level not yet through
    // R8 output read is the flop value
    cyc(1, 0, 0, 8'h01, 8'h00, "R2");
    cyc(0, 1, 0, 8'h12, 8'hFF, "R8");
    cyc(0, 0, 1, 8'h00, 8'hFF, "R8");
    // R10 read with write, read with command
    cyc(0, 1, 1, 8'h77, 8'hFF, "R10");     // returns 0x12
    cyc(0, 0, 1, 8'h00, 8'hFF, "R10");     // returns 0x77
    cyc(1, 0, 1, 8'h02, 8'hFF, "R10");     // old pointer -> 0x77
    cyc(0, 0, 1, 8'h00, 8'hFF, "R10");     // polarity now
    // R11 command and data together
    cyc(1, 1, 0, 8'h01, 8'hFF, "R11");
    cyc(0, 0, 1, 8'h00, 8'hFF, "R11");
    cyc(1, 0, 0, 8'h02, 8'hFF, "R11");
    cyc(0, 0, 1, 8'h00, 8'hFF, "R11");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] d;
      k = $urandom % 10;
      d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
      if ($urandom % 4 == 0) pins = 8'($urandom);
      case (k)
        0, 1: cyc(1, 0, 0, d, pins, "");
        2, 3: cyc(0, 1, 0, 8'($urandom), pins, "");
        4, 5, 6: cyc(0, 0, 1, 8'h00, pins, "");
        7: cyc(0, 1, 1, 8'($urandom), pins, "");
        8: cyc(1, 0, 1, d, pins, "");
        default: cyc(1, 1, $urandom % 2 == 1, d, pins, "");
      endcase
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule